// File: doc/BRIEF.md
# Note to Compare Value Interpolator

This block turns a musical request into a pair of 16-bit output-compare values for a timer channel. A request holds a 7-bit note, a 7-bit power level and a 14-bit pitch bend. Two read-only tables outside the block supply the raw values. The period table is looked up by note. The ON-time table is looked up by power and note together. The block forms the table addresses, interpolates linearly between two neighbouring notes according to the bend, and derives the OFF time as the period minus the ON time.

Both tables have registered read ports, and the block reads two adjacent notes at once through a pair of ports on each table. A request is launched with a one-cycle valid strobe, and a new request may be launched on every cycle. Each result appears together with a one-cycle done strobe, a fixed three cycles after its request. A note of zero or a power of zero means the channel is disabled, and that request returns zero for both values.

Top module: `note_cmp_interp`

## Requirements
- R1: The period table ports carry the lower note of the selected pair on `per_addr_a` and the upper note on `per_addr_b`. The upper note is the lower note plus one, except in the fallback case of R4.
- R2: The ON table addresses are `{req_power, note}`, with power in bits 13:7 and note in bits 6:0. Port a uses the lower note and port b uses the upper note.
- R3: Bend bits 13:12 select the pair. 00 gives note-2 and note-1, 01 gives note-1 and note, 10 gives note and note+1, and 11 gives note+1 and note+2. A bend of 0x2000 therefore addresses the note itself as the lower note.
- R4: When the lower note of the pair would be below 1, or the upper note would be above 127, no bend is applied. Both ports address the request's note and the fraction is 0.
- R5: The interpolated period and the interpolated ON time are each lo + floor((hi - lo) * frac / 4096). Here frac is bend bits 11:0, and lo and hi are the table entries of the lower and upper note.
- R6: The OFF output equals the interpolated period minus the interpolated ON time, modulo 2^16.
- R7: A request with note 0 or power 0 returns 0 on both `on_val` and `off_val`.
- R8: `done` is a one-cycle pulse exactly three cycles after the cycle in which `req_valid` was high. One request is accepted per cycle, fully pipelined.
- R9: Reset clears `done`, `on_val` and `off_val`. The outputs hold their values in every cycle without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Launches a request this cycle |
| req_note | input | 7 | Note number, 0 means disabled |
| req_power | input | 7 | Power level, 0 means disabled |
| req_bend | input | 14 | Pitch bend, 0x2000 is centre |
| per_addr_a | output | 7 | Period table address, lower note |
| per_addr_b | output | 7 | Period table address, upper note |
| per_data_a | input | 16 | Period table data for port a, one cycle after its address |
| per_data_b | input | 16 | Period table data for port b, one cycle after its address |
| on_addr_a | output | 14 | ON table address {power, lower note} |
| on_addr_b | output | 14 | ON table address {power, upper note} |
| on_data_a | input | 16 | ON table data for port a, one cycle after its address |
| on_data_b | input | 16 | ON table data for port b, one cycle after its address |
| done | output | 1 | Result valid pulse |
| on_val | output | 16 | ON compare value |
| off_val | output | 16 | OFF compare value |

## Verification
The synthetic period table falls with note number and the ON table rises with it. Interpolation is therefore tried with both negative and positive differences, which exposes a logical shift used where an arithmetic shift belongs. Several groups of bends are used:
- bends at the centre, at each pair selector and at the extreme fractions separate the four pair choices and catch off-by-one errors in the fraction;
- notes at 1, 2, 3, 126 and 127 with outward bends separate a valid edge pair from the fallback case;
- requests with a zero note or a zero power check the disable rule;
- back-to-back requests check that the pipeline keeps results apart;
- an isolated request followed by idle cycles pins the latency and the hold behaviour.

// File: rtl/nci_pkg.sv
package nci_pkg;
  // Which adjacent-note pair a bend addresses, relative to the request note.
  typedef enum logic [1:0] {
    PAIR_DN2 = 2'b00,
    PAIR_DN1 = 2'b01,
    PAIR_UP1 = 2'b10,
    PAIR_UP2 = 2'b11
  } pair_sel_e;
endpackage

// File: rtl/nci_pair_sel.sv
module nci_pair_sel #(
  parameter int NOTE_W = 7,
  parameter int BEND_W = 14,
  localparam int FRAC_W = BEND_W - 2
) (
  input  logic [NOTE_W-1:0] note,
  input  logic [BEND_W-1:0] bend,
  output logic [NOTE_W-1:0] lo_note,
  output logic [NOTE_W-1:0] hi_note,
  output logic [FRAC_W-1:0] frac
);
  import nci_pkg::*;

  localparam logic [NOTE_W:0] TWO     = (NOTE_W+1)'(2);
  localparam logic [NOTE_W:0] ONE     = (NOTE_W+1)'(1);
  localparam logic [NOTE_W:0] SUM_MIN = (NOTE_W+1)'(3);
  localparam logic [NOTE_W:0] SUM_MAX = (NOTE_W+1)'(2**NOTE_W);

  pair_sel_e       sel;
  logic [NOTE_W:0] sum;
  logic            in_range;

  // sum = note + sel; lower note = sum-2, upper note = sum-1
  always_comb begin
    sel      = pair_sel_e'(bend[BEND_W-1 -: 2]);
    sum      = {1'b0, note} + {{(NOTE_W-1){1'b0}}, sel};
    in_range = (sum >= SUM_MIN) && (sum <= SUM_MAX);
    if (in_range) begin
      lo_note = NOTE_W'(sum - TWO);
      hi_note = NOTE_W'(sum - ONE);
      frac    = bend[FRAC_W-1:0];
    end else begin
      lo_note = note;
      hi_note = note;
      frac    = '0;
    end
  end
endmodule

// File: rtl/nci_lerp.sv
module nci_lerp #(
  parameter int VAL_W  = 16,
  parameter int FRAC_W = 12,
  localparam int PW    = VAL_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [VAL_W-1:0]  lo_val,
  input  logic [VAL_W-1:0]  hi_val,
  input  logic [FRAC_W-1:0] frac,
  output logic [VAL_W-1:0]  res
);
  logic signed [VAL_W:0] diff;
  logic signed [PW-1:0]  prod;
  logic [VAL_W-1:0]      res_d;
  logic [VAL_W-1:0]      res_q;

  always_comb begin
    diff  = $signed({1'b0, hi_val}) - $signed({1'b0, lo_val});
    prod  = PW'(diff) * PW'($signed({1'b0, frac}));
    // arithmetic shift floors the step for falling tables as well
    res_d = VAL_W'($signed({{(FRAC_W+2){1'b0}}, lo_val}) + (prod >>> FRAC_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  res_q <= '0;
    else if (en) res_q <= res_d;
  end

  assign res = res_q;
endmodule

// File: rtl/note_cmp_interp.sv
module note_cmp_interp #(
  parameter int NOTE_W  = 7,
  parameter int POWER_W = 7,
  parameter int BEND_W  = 14,
  parameter int VAL_W   = 16,
  localparam int FRAC_W = BEND_W - 2,
  localparam int ON_AW  = POWER_W + NOTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [NOTE_W-1:0]  req_note,
  input  logic [POWER_W-1:0] req_power,
  input  logic [BEND_W-1:0]  req_bend,
  output logic [NOTE_W-1:0]  per_addr_a,
  output logic [NOTE_W-1:0]  per_addr_b,
  input  logic [VAL_W-1:0]   per_data_a,
  input  logic [VAL_W-1:0]   per_data_b,
  output logic [ON_AW-1:0]   on_addr_a,
  output logic [ON_AW-1:0]   on_addr_b,
  input  logic [VAL_W-1:0]   on_data_a,
  input  logic [VAL_W-1:0]   on_data_b,
  output logic               done,
  output logic [VAL_W-1:0]   on_val,
  output logic [VAL_W-1:0]   off_val
);
  logic [NOTE_W-1:0] lo_note, hi_note;
  logic [FRAC_W-1:0] frac_c;

  // stage 0: address formation (tables register the address)
  nci_pair_sel #(.NOTE_W(NOTE_W), .BEND_W(BEND_W)) u_pair (
    .note(req_note), .bend(req_bend),
    .lo_note(lo_note), .hi_note(hi_note), .frac(frac_c)
  );

  assign per_addr_a = lo_note;
  assign per_addr_b = hi_note;
  assign on_addr_a  = {req_power, lo_note};
  assign on_addr_b  = {req_power, hi_note};

  // stage 1: control travelling alongside the table read
  logic              s1_vld, s1_kill;
  logic [FRAC_W-1:0] s1_frac;
  logic              s1_kill_d;

  always_comb s1_kill_d = (req_note == '0) || (req_power == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_kill <= 1'b0;
      s1_frac <= '0;
    end else begin
      s1_vld <= req_valid;
      if (req_valid) begin
        s1_kill <= s1_kill_d;
        s1_frac <= frac_c;
      end
    end
  end

  // stage 2: interpolation of period (0) and ON time (1)
  logic [VAL_W-1:0] lo_v  [2];
  logic [VAL_W-1:0] hi_v  [2];
  logic [VAL_W-1:0] res_v [2];

  assign lo_v[0] = per_data_a;
  assign hi_v[0] = per_data_b;
  assign lo_v[1] = on_data_a;
  assign hi_v[1] = on_data_b;

  for (genvar g = 0; g < 2; g++) begin : g_lerp
    nci_lerp #(.VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_lerp (
      .clk(clk), .rst_n(rst_n), .en(s1_vld),
      .lo_val(lo_v[g]), .hi_val(hi_v[g]), .frac(s1_frac),
      .res(res_v[g])
    );
  end

  logic s2_vld, s2_kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_kill <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) s2_kill <= s1_kill;
    end
  end

  // stage 3: OFF derivation, disable, output register
  logic [VAL_W-1:0] on_d, off_d, on_q, off_q;
  logic             done_q;

  always_comb begin
    if (s2_kill) begin
      on_d  = '0;
      off_d = '0;
    end else begin
      on_d  = res_v[1];
      off_d = res_v[0] - res_v[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      on_q   <= '0;
      off_q  <= '0;
    end else begin
      done_q <= s2_vld;
      if (s2_vld) begin
        on_q  <= on_d;
        off_q <= off_d;
      end
    end
  end

  assign done    = done_q;
  assign on_val  = on_q;
  assign off_val = off_q;
endmodule

// File: rtl/nci_checker.sv
module nci_checker #(
  parameter int NOTE_W  = 7,
  parameter int POWER_W = 7,
  parameter int BEND_W  = 14,
  parameter int VAL_W   = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic [NOTE_W-1:0]         req_note,
  input logic [POWER_W-1:0]        req_power,
  input logic [BEND_W-1:0]         req_bend,
  input logic [NOTE_W-1:0]         per_addr_a,
  input logic [NOTE_W-1:0]         per_addr_b,
  input logic [POWER_W+NOTE_W-1:0] on_addr_a,
  input logic [POWER_W+NOTE_W-1:0] on_addr_b,
  input logic                      done,
  input logic [VAL_W-1:0]          on_val,
  input logic [VAL_W-1:0]          off_val
);
  localparam logic [BEND_W-1:0] CENTER = BEND_W'(1) << (BEND_W-1);

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##3 done); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid, 3)); // R8
  AST_PAIR_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (per_addr_b == per_addr_a + NOTE_W'(1)) ||
                  (per_addr_a == req_note && per_addr_b == req_note)); // R4
  AST_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (on_addr_a == {req_power, per_addr_a}) &&
                  (on_addr_b == {req_power, per_addr_b})); // R2
  AST_NO_BEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bend == CENTER) |-> per_addr_a == req_note); // R3
  AST_KILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_note == '0 || req_power == '0, 3)) |->
      (on_val == '0 && off_val == '0)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(on_val) && $stable(off_val))); // R9
endmodule

bind note_cmp_interp nci_checker #(
  .NOTE_W(NOTE_W), .POWER_W(POWER_W), .BEND_W(BEND_W), .VAL_W(VAL_W)
) u_nci_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_note(req_note), .req_power(req_power), .req_bend(req_bend),
  .per_addr_a(per_addr_a), .per_addr_b(per_addr_b),
  .on_addr_a(on_addr_a), .on_addr_b(on_addr_b),
  .done(done), .on_val(on_val), .off_val(off_val)
);

// File: tb/test_note_cmp_interp.sv
module test_note_cmp_interp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [6:0]  req_note, req_power;
  logic [13:0] req_bend;
  logic [6:0]  per_addr_a, per_addr_b;
  logic [15:0] per_data_a, per_data_b;
  logic [13:0] on_addr_a, on_addr_b;
  logic [15:0] on_data_a, on_data_b;
  logic        done;
  logic [15:0] on_val, off_val;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk; // 50 MHz

  note_cmp_interp i_note_cmp_interp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_note(req_note), .req_power(req_power), .req_bend(req_bend),
    .per_addr_a(per_addr_a), .per_addr_b(per_addr_b),
    .per_data_a(per_data_a), .per_data_b(per_data_b),
    .on_addr_a(on_addr_a), .on_addr_b(on_addr_b),
    .on_data_a(on_data_a), .on_data_b(on_data_b),
    .done(done), .on_val(on_val), .off_val(off_val)
  );

  // synthetic tables: period falls with note, ON time rises with note
  function automatic logic [15:0] pf(input logic [6:0] n);
    return 16'(40000 - 250 * int'(n));
  endfunction
  function automatic logic [15:0] of(input logic [6:0] p, input logic [6:0] n);
    return 16'(20 * int'(p) + 7 * int'(n));
  endfunction

  always @(posedge clk) begin
    per_data_a <= pf(per_addr_a);
    per_data_b <= pf(per_addr_b);
    on_data_a  <= of(on_addr_a[13:7], on_addr_a[6:0]);
    on_data_b  <= of(on_addr_b[13:7], on_addr_b[6:0]);
  end

  function automatic int lerp(input int a, input int b, input int f);
    int t;
    t = (b - a) * f;
    return a + (t >>> 12);
  endfunction

  function automatic bit is_fallback(input logic [6:0] n, input logic [13:0] b);
    int s;
    s = int'(n) + int'(b[13:12]);
    return (s < 3) || (s > 128);
  endfunction

  task automatic model(input logic [6:0] n, input logic [6:0] p, input logic [13:0] b,
                       output logic [15:0] e_on, output logic [15:0] e_off);
    int s, lo, hi, f, per, on;
    if (n == 0 || p == 0) begin
      e_on = '0; e_off = '0;
    end else begin
      s = int'(n) + int'(b[13:12]);
      if (is_fallback(n, b)) begin lo = int'(n); hi = int'(n); f = 0; end
      else begin lo = s - 2; hi = s - 1; f = int'(b[11:0]); end
      per   = lerp(int'(pf(7'(lo))), int'(pf(7'(hi))), f);
      on    = lerp(int'(of(p, 7'(lo))), int'(of(p, 7'(hi))), f);
      e_on  = 16'(on);
      e_off = 16'(per - on);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  typedef struct packed {
    logic [6:0]  note;
    logic [6:0]  power;
    logic [13:0] bend;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{7'd60,  7'd100, 14'h2000},
    '{7'd60,  7'd100, 14'h2800},
    '{7'd60,  7'd100, 14'h0000},
    '{7'd60,  7'd100, 14'h3FFF},
    '{7'd60,  7'd100, 14'h1234},
    '{7'd1,   7'd50,  14'h1000},
    '{7'd2,   7'd50,  14'h0000},
    '{7'd3,   7'd50,  14'h0ABC},
    '{7'd127, 7'd10,  14'h2000},
    '{7'd126, 7'd10,  14'h3000},
    '{7'd126, 7'd10,  14'h27FF},
    '{7'd0,   7'd100, 14'h2000},
    '{7'd60,  7'd0,   14'h2400},
    '{7'd127, 7'd127, 14'h1800},
    '{7'd90,  7'd77,  14'h2FFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] e_on, e_off, last_on, last_off;
    string t_on, t_off;
    rst_n = 1'b0; req_valid = 1'b0;
    req_note = '0; req_power = '0; req_bend = 14'h2000;
    repeat (3) @(negedge clk);
    chk("R9 reset done", 32'(done), 32'd0);
    chk("R9 reset on_val", 32'(on_val), 32'd0);
    chk("R9 reset off_val", 32'(off_val), 32'd0);
    rst_n = 1'b1;

    // address formation, observed on the table ports
    @(negedge clk);
    req_note = 7'd60; req_power = 7'd100; req_bend = 14'h0800;
    #1;
    chk("R3 sel00 lower", 32'(per_addr_a), 32'd58);
    chk("R1 sel00 upper", 32'(per_addr_b), 32'd59);
    chk("R2 on addr a", 32'(on_addr_a), 32'(100 * 128 + 58));
    chk("R2 on addr b", 32'(on_addr_b), 32'(100 * 128 + 59));
    req_bend = 14'h3000; #1;
    chk("R3 sel11 lower", 32'(per_addr_a), 32'd61);
    chk("R1 sel11 upper", 32'(per_addr_b), 32'd62);
    req_bend = 14'h2000; #1;
    chk("R3 centre lower", 32'(per_addr_a), 32'd60);
    req_note = 7'd2; req_bend = 14'h0000; #1;
    chk("R4 low edge a", 32'(per_addr_a), 32'd2);
    chk("R4 low edge b", 32'(per_addr_b), 32'd2);
    req_note = 7'd127; req_bend = 14'h2000; #1;
    chk("R4 high edge a", 32'(per_addr_a), 32'd127);
    chk("R4 high edge b", 32'(per_addr_b), 32'd127);

    // pipelined vector walk: result of vector k appears three negedges later
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        model(VECS[k-3].note, VECS[k-3].power, VECS[k-3].bend, e_on, e_off);
        if (VECS[k-3].note == 0 || VECS[k-3].power == 0) begin
          t_on = "R7 on"; t_off = "R7 off";
        end else if (is_fallback(VECS[k-3].note, VECS[k-3].bend)) begin
          t_on = "R4 on"; t_off = "R4 off";
        end else begin
          t_on = "R5 on"; t_off = "R6 off";
        end
        chk("R8 done pulse", 32'(done), 32'd1);
        chk(t_on, 32'(on_val), 32'(e_on));
        chk(t_off, 32'(off_val), 32'(e_off));
        last_on = e_on; last_off = e_off;
      end
      if (k < NV) begin
        req_note = VECS[k].note; req_power = VECS[k].power;
        req_bend = VECS[k].bend; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
    end

    // idle: outputs hold, no done
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 idle done", 32'(done), 32'd0);
      chk("R9 hold on", 32'(on_val), 32'(last_on));
      chk("R9 hold off", 32'(off_val), 32'(last_off));
    end

    // isolated request: exact latency and single-cycle pulse
    @(negedge clk);
    req_note = 7'd40; req_power = 7'd60; req_bend = 14'h2C00; req_valid = 1'b1;
    model(7'd40, 7'd60, 14'h2C00, e_on, e_off);
    @(negedge clk); req_valid = 1'b0;
    chk("R8 no early done 1", 32'(done), 32'd0);
    @(negedge clk);
    chk("R8 no early done 2", 32'(done), 32'd0);
    @(negedge clk);
    chk("R8 done at 3", 32'(done), 32'd1);
    chk("R5 isolated on", 32'(on_val), 32'(e_on));
    chk("R6 isolated off", 32'(off_val), 32'(e_off));
    @(negedge clk);
    chk("R8 pulse ends", 32'(done), 32'd0);

    finish_run();
  end
endmodule